// File: doc/BRIEF.md
# Boot Region Lock and Write Guard

This block sits in front of the array and page buffer of a 256K x 8 nonvolatile memory. It decides, write by write, whether a host write cycle may reach the array. It watches the active-low write strobe and the bus address and data. A strobe low time that is too short is treated as noise. Writes are refused while the supply-valid input is low, and for a programmable number of cycles after that input rises.

A write that survives these filters either belongs to a command sequence or is a plain program write. The block decodes four command sequences. The first sets a one-way lock on the lowest or the highest 8 KB boot region. The second requests chip erase. The other two enter and leave identification mode. In identification mode, reads at two fixed probe addresses return the lock status of each boot region.

The controller is a single command state machine with seven states:

- IDLE waits for the first unlock write.
- UNL1 follows the first unlock write.
- UNL2 follows the second unlock write and decodes the command byte.
- EXT follows the extended-command byte 80h.
- EXT1 follows the third unlock write.
- EXT2 follows the fourth unlock write and decodes the final command byte.
- LSEL waits for the region-select write.

Transitions:

- IDLE to UNL1 on AAh written at 5555h.
- UNL1 to UNL2 on 55h written at 2AAAh.
- UNL2 to EXT on 80h written at 5555h.
- UNL2 to IDLE on 90h (enter identification mode), on F0h (leave identification mode), or on any other write.
- EXT to EXT1 on AAh written at 5555h.
- EXT1 to EXT2 on 55h written at 2AAAh.
- EXT2 to LSEL on 40h written at 5555h.
- EXT2 to IDLE on 10h written at 5555h (chip erase) or on any other write.
- LSEL to IDLE on any write, locking the region that the write address falls in, if any.
- Any mismatch in UNL1, EXT or EXT1 returns to IDLE.

Top module: `boot_lock_guard`

## Requirements
- R1: A write event occurs when `we_n` is sampled high after being sampled low on at least MIN_LOW consecutive rising clock edges (default 2). A shorter low pulse produces no event and is neither programmed nor taken as a command step.
- R2: While `vdd_ok` is low, and until `vdd_ok` has been sampled high on PWR_DELAY consecutive rising edges, every write event is discarded. A drop of `vdd_ok` restarts the wait.
- R3: In IDLE, an accepted write event that is not AAh at address 5555h is a program write. `prog_ok` pulses for exactly one cycle, in the cycle after the edge where `we_n` is seen high. Writes consumed as command steps never pulse `prog_ok`.
- R4: The seven-write lock sequence sets a lock. Its first six writes are AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 40h@5555h, compared on address bits [14:0]. In the seventh write, address bits [17:13] select the region: all zero locks the low region, all one locks the high region, and any other value locks nothing.
- R5: A program write whose address lies in a locked region gives no `prog_ok`. Addresses outside every locked region, including the first address past a locked region's boundary, still give `prog_ok`.
- R6: The chip-erase sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. It pulses `erase_ok` for one cycle after its last write only when neither region is locked.
- R7: Lock bits are set-only. No command sequence, chip erase or supply drop clears them; only `rst_n` does.
- R8: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode, and AAh@5555h, 55h@2AAAh, F0h@5555h leaves it. `rd_data` is registered from the cycle where `rd_en` is high. In identification mode it is FFh for a locked region or FEh for an unlocked one, read at address 00002h (low region) and 3FFF2h (high region). Every other case gives 00h.
- R9: A write that does not match the expected step in the middle of a sequence is dropped. It gives no `prog_ok`, changes no lock, and returns the machine to IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; power-on state, clears locks |
| vdd_ok | input | 1 | Supply above write threshold |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 18 | Byte address for writes and reads |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Status read request |
| prog_ok | output | 1 | One-cycle pulse: program write allowed |
| erase_ok | output | 1 | One-cycle pulse: chip erase allowed |
| rd_data | output | 8 | Status read byte |

## Verification
The bench probes the glitch threshold at MIN_LOW-1 and MIN_LOW cycles. A filter off by one would either program on noise or drop legitimate writes. It writes part-way through the power-up wait and again just after a brief supply drop. A guard that does not restart its count would accept these writes.

It programs the last byte of the low region and the first byte past it. A lock decoded on the wrong address bits would refuse or allow the wrong side of that boundary. It also checks four further behaviours:

- An aborted lock sequence and a region-select write that falls in the middle of the array both leave the locks clear.
- Chip erase is refused once any lock is set.
- Locks survive a supply drop.
- Only reset clears the locks.

// File: rtl/bbl_pkg.sv
package bbl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UNL1,
        S_UNL2,
        S_EXT,
        S_EXT1,
        S_EXT2,
        S_LSEL
    } seq_state_t;

    localparam logic [14:0] A_KEY1 = 15'h5555;
    localparam logic [14:0] A_KEY2 = 15'h2AAA;

    localparam logic [7:0] D_KEY1    = 8'hAA;
    localparam logic [7:0] D_KEY2    = 8'h55;
    localparam logic [7:0] D_EXTEND  = 8'h80;
    localparam logic [7:0] D_ID_IN   = 8'h90;
    localparam logic [7:0] D_ID_OUT  = 8'hF0;
    localparam logic [7:0] D_ERASE   = 8'h10;
    localparam logic [7:0] D_LOCK    = 8'h40;

    localparam logic [7:0] ST_LOCKED = 8'hFF;
    localparam logic [7:0] ST_OPEN   = 8'hFE;
    localparam logic [7:0] ST_NONE   = 8'h00;

endpackage

// File: rtl/bbl_we_filter.sv
module bbl_we_filter #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 8,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              evt,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            ev_addr <= '0;
            ev_data <= '0;
        end else if (!we_n) begin
            if (low_cnt != CMAX) low_cnt <= low_cnt + 1'b1;
            ev_addr <= addr;
            ev_data <= wdata;
        end else begin
            low_cnt <= '0;
        end
    end

    assign evt = we_n && (low_cnt == CMAX);
endmodule

// File: rtl/bbl_pwr_gate.sv
module bbl_pwr_gate #(
    parameter int PWR_DELAY = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_ok,
    output logic guard_ok
);
    localparam int PW = $clog2(PWR_DELAY + 1);
    localparam logic [PW-1:0] PMAX = PW'(PWR_DELAY);

    logic [PW-1:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (!vdd_ok) begin
            wait_cnt <= '0;
        end else if (wait_cnt != PMAX) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    assign guard_ok = vdd_ok && (wait_cnt == PMAX);
endmodule

// File: rtl/bbl_seq.sv
module bbl_seq
    import bbl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int REGION_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [7:0]        ev_data,
    output logic              prog_ok,
    output logic              erase_ok,
    output logic              lock_lo,
    output logic              lock_hi,
    output logic              id_mode
);
    localparam int TOP_W = ADDR_W - REGION_W;

    seq_state_t state, state_n;

    logic at_k1, at_k2, in_lo, in_hi;
    logic do_prog, do_erase, set_lo, set_hi, id_set, id_clr;

    assign at_k1 = (ev_addr[14:0] == A_KEY1);
    assign at_k2 = (ev_addr[14:0] == A_KEY2);
    assign in_lo = (ev_addr[ADDR_W-1:REGION_W] == {TOP_W{1'b0}});
    assign in_hi = (ev_addr[ADDR_W-1:REGION_W] == {TOP_W{1'b1}});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // next state and one-cycle actions
    always_comb begin
        state_n  = state;
        do_prog  = 1'b0;
        do_erase = 1'b0;
        set_lo   = 1'b0;
        set_hi   = 1'b0;
        id_set   = 1'b0;
        id_clr   = 1'b0;
        if (evt) begin
            unique case (state)
                S_IDLE: begin
                    if (at_k1 && ev_data == D_KEY1) state_n = S_UNL1;
                    else                            do_prog = 1'b1;
                end
                S_UNL1: begin
                    state_n = (at_k2 && ev_data == D_KEY2) ? S_UNL2 : S_IDLE;
                end
                S_UNL2: begin
                    state_n = S_IDLE;
                    if (at_k1) begin
                        if (ev_data == D_EXTEND)      state_n = S_EXT;
                        else if (ev_data == D_ID_IN)  id_set  = 1'b1;
                        else if (ev_data == D_ID_OUT) id_clr  = 1'b1;
                    end
                end
                S_EXT: begin
                    state_n = (at_k1 && ev_data == D_KEY1) ? S_EXT1 : S_IDLE;
                end
                S_EXT1: begin
                    state_n = (at_k2 && ev_data == D_KEY2) ? S_EXT2 : S_IDLE;
                end
                S_EXT2: begin
                    state_n = S_IDLE;
                    if (at_k1) begin
                        if (ev_data == D_LOCK)       state_n  = S_LSEL;
                        else if (ev_data == D_ERASE) do_erase = 1'b1;
                    end
                end
                S_LSEL: begin
                    state_n = S_IDLE;
                    if (in_lo)      set_lo = 1'b1;
                    else if (in_hi) set_hi = 1'b1;
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // registered outputs and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_ok  <= 1'b0;
            erase_ok <= 1'b0;
            lock_lo  <= 1'b0;
            lock_hi  <= 1'b0;
            id_mode  <= 1'b0;
        end else begin
            prog_ok  <= do_prog && !(in_lo && lock_lo) && !(in_hi && lock_hi);
            erase_ok <= do_erase && !lock_lo && !lock_hi;
            lock_lo  <= lock_lo | set_lo;
            lock_hi  <= lock_hi | set_hi;
            if (id_set)      id_mode <= 1'b1;
            else if (id_clr) id_mode <= 1'b0;
        end
    end
endmodule

// File: rtl/bbl_probe.sv
module bbl_probe
    import bbl_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] PROBE_LO = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] PROBE_HI = {ADDR_W{1'b1}} - ADDR_W'(13);

    logic [7:0] rd_n;

    always_comb begin
        rd_n = ST_NONE;
        if (rd_en && id_mode) begin
            if (addr == PROBE_LO)      rd_n = lock_lo ? ST_LOCKED : ST_OPEN;
            else if (addr == PROBE_HI) rd_n = lock_hi ? ST_LOCKED : ST_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= ST_NONE;
        else        rd_data <= rd_n;
    end
endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard #(
    parameter int ADDR_W    = 18,
    parameter int REGION_W  = 13,
    parameter int MIN_LOW   = 2,
    parameter int PWR_DELAY = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vdd_ok,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    output logic              prog_ok,
    output logic              erase_ok,
    output logic [7:0]        rd_data
);
    logic              raw_evt, guard_ok, wr_evt;
    logic [ADDR_W-1:0] ev_addr;
    logic [7:0]        ev_data;
    logic              lock_lo, lock_hi, id_mode;

    bbl_we_filter #(.ADDR_W(ADDR_W), .DATA_W(8), .MIN_LOW(MIN_LOW)) u_filt (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .evt(raw_evt), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    bbl_pwr_gate #(.PWR_DELAY(PWR_DELAY)) u_pwr (
        .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .guard_ok(guard_ok)
    );

    assign wr_evt = raw_evt && guard_ok;

    bbl_seq #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .evt(wr_evt), .ev_addr(ev_addr),
        .ev_data(ev_data), .prog_ok(prog_ok), .erase_ok(erase_ok),
        .lock_lo(lock_lo), .lock_hi(lock_hi), .id_mode(id_mode)
    );

    bbl_probe #(.ADDR_W(ADDR_W)) u_probe (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/boot_lock_guard_chk.sv
module boot_lock_guard_chk #(
    parameter int ADDR_W   = 18,
    parameter int REGION_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vdd_ok,
    input logic              rd_en,
    input logic              wr_evt,
    input logic              prog_ok,
    input logic              erase_ok,
    input logic              lock_lo,
    input logic              lock_hi,
    input logic [ADDR_W-1:0] ev_addr,
    input logic [7:0]        rd_data
);
    localparam int TOP_W = ADDR_W - REGION_W;

    // R3: a permitted program needs an accepted write event one cycle earlier
    assert_prog_needs_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> $past(wr_evt));

    // R2: no write is let through in the cycle after the supply was invalid
    assert_no_write_low_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vdd_ok |=> !prog_ok && !erase_ok);

    // R5: a program never hits a region that was already locked
    assert_no_prog_locked_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> !($past(lock_lo) && $past(ev_addr[ADDR_W-1:REGION_W]) == {TOP_W{1'b0}}));
    assert_no_prog_locked_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_ok |-> !($past(lock_hi) && $past(ev_addr[ADDR_W-1:REGION_W]) == {TOP_W{1'b1}}));

    // R6: erase only while both regions were open
    assert_erase_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_ok |-> $past(!lock_lo && !lock_hi));

    // R7: locks never clear while out of reset
    assert_lock_lo_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_lo) |-> lock_lo);
    assert_lock_hi_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_hi) |-> lock_hi);

    // R8: status byte is zero without a read and only takes the three codes
    assert_rd_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rd_data == 8'h00);
    assert_rd_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == 8'h00 || rd_data == 8'hFE || rd_data == 8'hFF);

    // R3/R6: program and erase pulses are exclusive
    assert_pulse_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_ok && erase_ok));
endmodule

bind boot_lock_guard boot_lock_guard_chk #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .rd_en(rd_en), .wr_evt(wr_evt),
    .prog_ok(prog_ok), .erase_ok(erase_ok), .lock_lo(lock_lo), .lock_hi(lock_hi),
    .ev_addr(ev_addr), .rd_data(rd_data)
);

// File: tb/boot_lock_guard_bench.sv
module boot_lock_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_LOW    = 2;
    localparam int PWR_DELAY  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vdd_ok = 1'b0;
    logic        we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic        prog_ok, erase_ok;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    logic got_prog, got_erase;
    logic m_lo = 1'b0;
    logic m_hi = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_lock_guard #(.MIN_LOW(MIN_LOW), .PWR_DELAY(PWR_DELAY)) u_boot_lock_guard (
        .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .we_n(we_n), .addr(addr),
        .wdata(wdata), .rd_en(rd_en), .prog_ok(prog_ok), .erase_ok(erase_ok),
        .rd_data(rd_data)
    );

    function automatic logic exp_prog(input logic [17:0] a, input int width,
                                      input logic lo, input logic hi);
        if (width < MIN_LOW) return 1'b0;
        if (lo && a[17:13] == 5'h00) return 1'b0;
        if (hi && a[17:13] == 5'h1F) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] exp_status(input logic lk);
        return lk ? 8'hFF : 8'hFE;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d, input int width);
        @(negedge clk);
        we_n = 1'b0; addr = a; wdata = d;
        repeat (width) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        got_prog = prog_ok;
        got_erase = erase_ok;
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic unl();
        wr(18'h05555, 8'hAA, MIN_LOW);
        check("R3 command write no prog", int'(got_prog), 0);
        wr(18'h02AAA, 8'h55, MIN_LOW);
        check("R3 command write no prog", int'(got_prog), 0);
    endtask

    task automatic ext_prefix();
        unl();
        wr(18'h05555, 8'h80, MIN_LOW);
        unl();
    endtask

    task automatic lock_region(input logic [17:0] sel);
        ext_prefix();
        wr(18'h05555, 8'h40, MIN_LOW);
        wr(sel, 8'h00, MIN_LOW);
        check("R4 select write no prog", int'(got_prog), 0);
    endtask

    task automatic id_enter();
        unl();
        wr(18'h05555, 8'h90, MIN_LOW);
    endtask

    task automatic id_exit();
        unl();
        wr(18'h05555, 8'hF0, MIN_LOW);
    endtask

    task automatic probe_both(input string req);
        logic [7:0] v;
        id_enter();
        rd(18'h00002, v);
        check(req, int'(v), int'(exp_status(m_lo)));
        rd(18'h3FFF2, v);
        check(req, int'(v), int'(exp_status(m_hi)));
        id_exit();
    endtask

    task automatic power_up();
        @(negedge clk);
        vdd_ok = 1'b1;
        repeat (PWR_DELAY + 2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R3 reset prog_ok", int'(prog_ok), 0);
        check("R6 reset erase_ok", int'(erase_ok), 0);
        check("R8 reset rd_data", int'(rd_data), 0);

        // R2: supply low, then inside the power-up wait
        wr(18'h10000, 8'h12, MIN_LOW);
        check("R2 write with supply low", int'(got_prog), 0);
        @(negedge clk); vdd_ok = 1'b1;
        repeat (10) @(negedge clk);
        wr(18'h10000, 8'h12, MIN_LOW);
        check("R2 write during power-up wait", int'(got_prog), 0);
        repeat (PWR_DELAY) @(negedge clk);
        wr(18'h10000, 8'h12, MIN_LOW);
        check("R3 program after wait", int'(got_prog), 1);

        // R1: glitch threshold
        wr(18'h10001, 8'h34, MIN_LOW - 1);
        check("R1 short strobe ignored", int'(got_prog), 0);
        wr(18'h10001, 8'h34, MIN_LOW);
        check("R1 minimum strobe accepted", int'(got_prog), 1);
        // short AA@5555 must not start a sequence: the next write is a program
        wr(18'h05555, 8'hAA, MIN_LOW - 1);
        wr(18'h02AAA, 8'h55, MIN_LOW);
        check("R1 glitch is no command step", int'(got_prog), 1);

        // R8: ID mode reads with no locks, other address, outside the mode
        id_enter();
        rd(18'h00002, v);
        check("R8 low probe open", int'(v), 8'hFE);
        rd(18'h3FFF2, v);
        check("R8 high probe open", int'(v), 8'hFE);
        rd(18'h00005, v);
        check("R8 non-probe address", int'(v), 8'h00);
        id_exit();
        rd(18'h00002, v);
        check("R8 probe outside ID mode", int'(v), 8'h00);

        // R6: erase allowed while open
        ext_prefix();
        wr(18'h05555, 8'h10, MIN_LOW);
        check("R6 erase allowed unlocked", int'(got_erase), 1);
        check("R3 erase step no prog", int'(got_prog), 0);

        // R9: aborted lock sequence
        unl();
        wr(18'h05555, 8'h80, MIN_LOW);
        wr(18'h05555, 8'hAA, MIN_LOW);
        wr(18'h05555, 8'h33, MIN_LOW);
        check("R9 mismatch dropped", int'(got_prog), 0);
        wr(18'h00100, 8'h77, MIN_LOW);
        check("R9 idle after abort, low open", int'(got_prog), 1);

        // R4: select write in the middle locks nothing
        lock_region(18'h20000);
        wr(18'h00100, 8'h77, MIN_LOW);
        check("R4 middle select no lock lo", int'(got_prog), 1);
        wr(18'h3E100, 8'h77, MIN_LOW);
        check("R4 middle select no lock hi", int'(got_prog), 1);

        // R4/R5: lock low region
        lock_region(18'h01000);
        m_lo = 1'b1;
        wr(18'h00010, 8'h5A, MIN_LOW);
        check("R5 low locked refused", int'(got_prog), 0);
        wr(18'h01FFF, 8'h5A, MIN_LOW);
        check("R5 low boundary refused", int'(got_prog), 0);
        wr(18'h02000, 8'h5A, MIN_LOW);
        check("R5 past boundary allowed", int'(got_prog), 1);
        wr(18'h3FFFF, 8'h5A, MIN_LOW);
        check("R5 high still open", int'(got_prog), 1);
        probe_both("R8 probe after low lock");

        // R6: erase refused once locked
        ext_prefix();
        wr(18'h05555, 8'h10, MIN_LOW);
        check("R6 erase refused locked", int'(got_erase), 0);

        // random program writes against the model
        for (int i = 0; i < 300; i++) begin
            logic [17:0] a;
            logic [7:0] d;
            int w;
            a = 18'($urandom);
            if (($urandom % 4) == 0) a[17:13] = 5'h00;
            d = 8'($urandom);
            if (d == 8'hAA) d = 8'h55;
            w = 1 + int'($urandom % 3);
            wr(a, d, w);
            check("R1/R5 random program", int'(got_prog), int'(exp_prog(a, w, m_lo, m_hi)));
        end

        // lock high region
        lock_region(18'h3E000);
        m_hi = 1'b1;
        wr(18'h3E000, 8'h11, MIN_LOW);
        check("R5 high locked refused", int'(got_prog), 0);
        wr(18'h3DFFF, 8'h11, MIN_LOW);
        check("R5 below high boundary allowed", int'(got_prog), 1);
        probe_both("R8 probe both locked");

        // R7 and R2: supply drop keeps locks, restarts wait
        @(negedge clk); vdd_ok = 1'b0;
        @(negedge clk); vdd_ok = 1'b1;
        wr(18'h10000, 8'h01, MIN_LOW);
        check("R2 wait restarts after drop", int'(got_prog), 0);
        repeat (PWR_DELAY) @(negedge clk);
        wr(18'h10000, 8'h01, MIN_LOW);
        check("R2 program after new wait", int'(got_prog), 1);
        probe_both("R7 locks survive supply drop");

        // R7: reset clears locks
        @(negedge clk); rst_n = 1'b0; vdd_ok = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lo = 1'b0; m_hi = 1'b0;
        power_up();
        probe_both("R7 reset clears locks");
        wr(18'h00010, 8'h22, MIN_LOW);
        check("R7 low writable after reset", int'(got_prog), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule